// File: doc/BRIEF.md
# Log-Frequency PWM Generator Bank

A bank of pulse-width generators that share one timebase. The period of every generator is a power of two of a base tick, so a single exponent register steps the output frequency in octaves. Each generator holds its own 8-bit duty value and its own 4-bit line select, and its waveform is routed onto one line of a 16-line output vector. Where two generators pick the same line, the line carries the OR of both.

The duty value is a fraction of 256. The bank maps the position inside the period onto an 8-bit phase and drives a generator high while that phase is below its duty. With small exponents the period has fewer than 256 ticks, so only the upper bits of the duty still matter and the duty resolution drops. Writes to the exponent, the duties and the selects land in shadow registers. They are copied to the working set only when the period wraps, so a period in progress is never cut short or stretched.

Top module: `logpwm_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, all output lines go low on that edge. The exponent, all duties and the period counter clear to 0, and generator g selects line g.
- R2: One base tick occurs every `TICK_DIV` clock cycles (default 2). With working exponent p, the period counter runs 0 to 2^p−1, advancing by one per tick, so a period lasts `TICK_DIV`·2^p cycles.
- R3: A generator is high while its phase floor(count·256/2^p) is below its duty. A duty of 0 never drives a line.
- R4: For p < 8 only the upper p duty bits are resolved. Duties 1 and 64 at p = 2 give identical waveforms, and duty 255 at p = 2 holds the line high.
- R5: The 4-bit select of a generator names the output line (0 to 15) it drives.
- R6: If several generators select one line, that line is the OR of their waveforms.
- R7: Exponent, duty and select writes are held. They take effect together on the tick that ends the current period, and the counter restarts at 0 on that tick.
- R8: Outputs are registered. The lines seen in a cycle reflect the counter and working settings of the cycle before.
- R9: A line selected by no generator stays low, so at most four lines are high at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exp_we | input | 1 | Write strobe for the period exponent |
| exp_wdata | input | 4 | New period exponent |
| duty_we | input | 1 | Write strobe for a duty value |
| duty_gen | input | 2 | Generator whose duty is written |
| duty_wdata | input | 8 | New duty value (fraction of 256) |
| sel_we | input | 1 | Write strobe for a line select |
| sel_gen | input | 2 | Generator whose select is written |
| sel_wdata | input | 4 | Output line index for that generator |
| pwm_out | output | 16 | Output line vector |

## Verification
A write reaches a shadow register on the next edge. It is copied to the working set only on the tick that ends the period, which can be anywhere from 1 to `TICK_DIV`·2^p cycles later, and the lines show its effect one cycle after that because the output is registered. The bench therefore keeps a behavioural model that mirrors the tick phase, the period position and the pending and working settings. At every falling edge it compares all sixteen lines with the model's prediction, so each result is checked in exactly the cycle it is due, whatever the period length. Directed checks at a small exponent confirm the reduced duty resolution and the OR of shared lines without relying on the model.

// File: rtl/logpwm_pkg.sv
// Shared sizes for the log-frequency PWM bank.
// Assumes: callers override these only together with the top parameters.
package logpwm_pkg;
    localparam int unsigned DUTY_BITS = 8;   // duty is a fraction of 2**DUTY_BITS
    localparam int unsigned EXP_BITS  = 4;   // exponent field width
endpackage

// File: rtl/logpwm_timebase.sv
// Shared timebase: tick prescaler, period counter and the working exponent.
// Assumes: exponent writes are single-cycle strobes; the new exponent is
// adopted only on the tick that ends the running period.
module logpwm_timebase #(
    parameter int unsigned EXP_W    = 4,
    parameter int unsigned TICK_DIV = 2,
    localparam int unsigned CNT_W   = (1 << EXP_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exp_we,
    input  logic [EXP_W-1:0] exp_wdata,
    output logic             tick,
    output logic             wrap,
    output logic [CNT_W-1:0] cnt,
    output logic [EXP_W-1:0] act_exp
);
    localparam int unsigned TDIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [EXP_W-1:0] pend_exp;
    logic [CNT_W:0]   last_pos;

    // Tick prescaler: one tick every TICK_DIV clocks.
    generate
        if (TICK_DIV > 1) begin : g_div
            logic [TDIV_W-1:0] div_q;
            always_ff @(posedge clk) begin
                if (!rst_n || tick) div_q <= '0;
                else                div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == TDIV_W'(TICK_DIV - 1));
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

    // Last counter value of the current period.
    always_comb last_pos = ((CNT_W + 1)'(1) << act_exp) - 1'b1;
    assign wrap = tick && ({1'b0, cnt} == last_pos);

    // Period counter: advance on tick, restart at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n || wrap) cnt <= '0;
        else if (tick)      cnt <= cnt + 1'b1;
    end

    // Pending exponent: captures writes at once.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_exp <= '0;
        else if (exp_we) pend_exp <= exp_wdata;
    end

    // Working exponent: adopted at the period end only.
    always_ff @(posedge clk) begin
        if (!rst_n)    act_exp <= '0;
        else if (wrap) act_exp <= pend_exp;
    end
endmodule

// File: rtl/logpwm_chan.sv
// One generator: shadow and working duty/select, phase compare, line decode.
// Assumes: counter value is below 2**act_exp, so the scaled phase fits
// in DUTY_W bits.
module logpwm_chan #(
    parameter int unsigned EXP_W     = 4,
    parameter int unsigned DUTY_W    = 8,
    parameter int unsigned NUM_LINES = 16,
    parameter int unsigned RESET_SEL = 0,
    localparam int unsigned CNT_W    = (1 << EXP_W) - 1,
    localparam int unsigned LINE_W   = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wrap,
    input  logic [CNT_W-1:0]     cnt,
    input  logic [EXP_W-1:0]     act_exp,
    input  logic                 duty_we,
    input  logic [DUTY_W-1:0]    duty_wdata,
    input  logic                 sel_we,
    input  logic [LINE_W-1:0]    sel_wdata,
    output logic [NUM_LINES-1:0] drive
);
    logic [DUTY_W-1:0]       pend_duty, act_duty;
    logic [LINE_W-1:0]       pend_sel, act_sel;
    logic [CNT_W+DUTY_W-1:0] scaled;
    logic [DUTY_W-1:0]       phase;

    // Shadow registers: capture writes at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_duty <= '0;
            pend_sel  <= LINE_W'(RESET_SEL);
        end else begin
            if (duty_we) pend_duty <= duty_wdata;
            if (sel_we)  pend_sel  <= sel_wdata;
        end
    end

    // Working registers: copied from the shadows at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_duty <= '0;
            act_sel  <= LINE_W'(RESET_SEL);
        end else if (wrap) begin
            act_duty <= pend_duty;
            act_sel  <= pend_sel;
        end
    end

    // Phase: counter scaled to a DUTY_W-bit fraction of the period.
    always_comb begin
        scaled = {cnt, {DUTY_W{1'b0}}} >> act_exp;
        phase  = scaled[DUTY_W-1:0];
    end

    // Line decode: one-hot onto the selected line while high.
    always_comb begin
        if (phase < act_duty) drive = {{(NUM_LINES-1){1'b0}}, 1'b1} << act_sel;
        else                  drive = '0;
    end
endmodule

// File: rtl/logpwm_bank.sv
// Top: shared timebase, NUM_GEN generators, OR merge and output register.
// Assumes: write strobes are synchronous to clk and one cycle wide.
module logpwm_bank #(
    parameter int unsigned NUM_GEN   = 4,
    parameter int unsigned NUM_LINES = 16,
    parameter int unsigned TICK_DIV  = 2,
    localparam int unsigned EXP_W    = logpwm_pkg::EXP_BITS,
    localparam int unsigned DUTY_W   = logpwm_pkg::DUTY_BITS,
    localparam int unsigned GEN_W    = $clog2(NUM_GEN),
    localparam int unsigned LINE_W   = $clog2(NUM_LINES),
    localparam int unsigned CNT_W    = (1 << EXP_W) - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 exp_we,
    input  logic [EXP_W-1:0]     exp_wdata,
    input  logic                 duty_we,
    input  logic [GEN_W-1:0]     duty_gen,
    input  logic [DUTY_W-1:0]    duty_wdata,
    input  logic                 sel_we,
    input  logic [GEN_W-1:0]     sel_gen,
    input  logic [LINE_W-1:0]    sel_wdata,
    output logic [NUM_LINES-1:0] pwm_out
);
    logic                 tick, wrap;
    logic [CNT_W-1:0]     cnt;
    logic [EXP_W-1:0]     act_exp;
    logic [NUM_LINES-1:0] drive [NUM_GEN];
    logic [NUM_LINES-1:0] merged;

    logpwm_timebase #(.EXP_W(EXP_W), .TICK_DIV(TICK_DIV)) u_tb (
        .clk(clk), .rst_n(rst_n), .exp_we(exp_we), .exp_wdata(exp_wdata),
        .tick(tick), .wrap(wrap), .cnt(cnt), .act_exp(act_exp)
    );

    generate
        for (genvar g = 0; g < NUM_GEN; g++) begin : g_chan
            logpwm_chan #(
                .EXP_W(EXP_W), .DUTY_W(DUTY_W), .NUM_LINES(NUM_LINES),
                .RESET_SEL(g % NUM_LINES)
            ) u_chan (
                .clk(clk), .rst_n(rst_n), .wrap(wrap), .cnt(cnt),
                .act_exp(act_exp),
                .duty_we(duty_we && (duty_gen == GEN_W'(g))),
                .duty_wdata(duty_wdata),
                .sel_we(sel_we && (sel_gen == GEN_W'(g))),
                .sel_wdata(sel_wdata),
                .drive(drive[g])
            );
        end
    endgenerate

    // Merge: generators sharing a line are ORed.
    always_comb begin
        merged = '0;
        for (int g = 0; g < NUM_GEN; g++) merged = merged | drive[g];
    end

    // Output register: lines change one cycle after the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_out <= '0;
        else        pwm_out <= merged;
    end
endmodule

// File: rtl/logpwm_bank_chk.sv
// Checker for logpwm_bank, attached by bind; watches ports and timebase state.
module logpwm_bank_chk #(
    parameter int unsigned NUM_GEN   = 4,
    parameter int unsigned NUM_LINES = 16,
    parameter int unsigned EXP_W     = 4,
    localparam int unsigned CNT_W    = (1 << EXP_W) - 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] pwm_out,
    input logic                 tick,
    input logic                 wrap,
    input logic [CNT_W-1:0]     cnt,
    input logic [EXP_W-1:0]     act_exp
);
    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> (pwm_out == '0)); // R1

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap) |=> (cnt == $past(cnt) + 1'b1)); // R2

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt)); // R2

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt} < ((CNT_W + 1)'(1) << act_exp))); // R2

    AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0)); // R7

    AST_EXP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(act_exp)); // R7

    AST_LINES_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pwm_out) <= NUM_GEN)); // R9
endmodule

bind logpwm_bank logpwm_bank_chk #(
    .NUM_GEN(NUM_GEN), .NUM_LINES(NUM_LINES), .EXP_W(EXP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .tick(tick),
    .wrap(wrap), .cnt(cnt), .act_exp(act_exp)
);

// File: tb/logpwm_bank_tb_top.sv
// Bench: behavioural reference compared on every clock, plus directed checks.
module logpwm_bank_tb_top;
    localparam int NG = 4;
    localparam int NL = 16;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exp_we = 1'b0;
    logic [3:0]  exp_wdata = '0;
    logic        duty_we = 1'b0;
    logic [1:0]  duty_gen = '0;
    logic [7:0]  duty_wdata = '0;
    logic        sel_we = 1'b0;
    logic [1:0]  sel_gen = '0;
    logic [3:0]  sel_wdata = '0;
    logic [15:0] pwm_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;
    bit started = 1'b0;
    string tag = "R1";

    always #2.5 clk = ~clk;  // 200 MHz

    logpwm_bank #(.NUM_GEN(NG), .NUM_LINES(NL), .TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .exp_we(exp_we), .exp_wdata(exp_wdata),
        .duty_we(duty_we), .duty_gen(duty_gen), .duty_wdata(duty_wdata),
        .sel_we(sel_we), .sel_gen(sel_gen), .sel_wdata(sel_wdata),
        .pwm_out(pwm_out)
    );

    // Reference model state
    int m_tick, m_cnt, m_pexp, m_aexp;
    int m_pdu[NG], m_adu[NG], m_psel[NG], m_asel[NG];
    logic [15:0] m_out;

    always @(posedge clk) begin
        logic [15:0] nxt;
        bit t, w;
        started <= 1'b1;
        if (!rst_n) begin
            m_tick = 0; m_cnt = 0; m_pexp = 0; m_aexp = 0; m_out = '0;
            for (int g = 0; g < NG; g++) begin
                m_pdu[g] = 0; m_adu[g] = 0; m_psel[g] = g; m_asel[g] = g;
            end
        end else begin
            nxt = '0;
            for (int g = 0; g < NG; g++)
                if (((m_cnt * 256) >> m_aexp) < m_adu[g]) nxt[m_asel[g]] = 1'b1;
            t = (m_tick == DIV - 1);
            m_tick = t ? 0 : m_tick + 1;
            w = t && (m_cnt == (1 << m_aexp) - 1);
            if (w) begin
                m_cnt = 0; m_aexp = m_pexp;
                for (int g = 0; g < NG; g++) begin
                    m_adu[g] = m_pdu[g]; m_asel[g] = m_psel[g];
                end
            end else if (t) m_cnt = m_cnt + 1;
            if (exp_we)  m_pexp = exp_wdata;
            if (duty_we) m_pdu[duty_gen] = duty_wdata;
            if (sel_we)  m_psel[sel_gen] = sel_wdata;
            m_out = nxt;
        end
    end

    // Per-cycle comparison against the model (tag names the phase's requirement)
    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (pwm_out !== m_out) begin
                failures++;
                $display("FAIL %s cycle %0d: pwm_out=%h expected=%h", tag, cycles, pwm_out, m_out);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: cycles=%0d expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_exp(input int v);
        @(negedge clk); exp_we = 1'b1; exp_wdata = 4'(v);
        @(negedge clk); exp_we = 1'b0;
    endtask

    task automatic wr_duty(input int g, input int v);
        @(negedge clk); duty_we = 1'b1; duty_gen = 2'(g); duty_wdata = 8'(v);
        @(negedge clk); duty_we = 1'b0;
    endtask

    task automatic wr_sel(input int g, input int l);
        @(negedge clk); sel_we = 1'b1; sel_gen = 2'(g); sel_wdata = 4'(l);
        @(negedge clk); sel_we = 1'b0;
    endtask

    initial begin
        // R1: reset clears lines
        tag = "R1";
        wait_cyc(4);
        chk("R1 reset lines low", pwm_out, 16'h0000);
        rst_n = 1'b1;
        wait_cyc(6);
        chk("R1 zero duty after reset", pwm_out, 16'h0000);

        // R5: route generator 0 to line 5 at exponent 3
        tag = "R5";
        wr_sel(0, 5); wr_duty(0, 128); wr_exp(3);
        wait_cyc(60);

        // R3 / R2: long period, several duties on default lines
        tag = "R3";
        wr_exp(9); wr_duty(1, 10); wr_duty(2, 200); wr_duty(3, 0);
        wait_cyc(2300);

        // R4: reduced resolution at exponent 2
        tag = "R4";
        wr_exp(2); wr_duty(0, 1); wr_duty(1, 64); wr_duty(2, 255);
        wait_cyc(1100);
        for (int i = 0; i < 16; i++) begin
            chk("R4 duty1 vs duty64", {15'd0, pwm_out[5]}, {15'd0, pwm_out[1]});
            chk("R4 duty255 high", {15'd0, pwm_out[2]}, 16'h0001);
            @(negedge clk);
        end

        // R6: two generators on line 5; R9: unused lines stay low
        tag = "R6";
        wr_sel(3, 5); wr_duty(3, 200);
        wait_cyc(40);
        for (int i = 0; i < 8; i++) begin
            chk("R6 shared line high", {15'd0, pwm_out[5]}, 16'h0001);
            chk("R9 unused lines low", pwm_out & 16'hFFD9, 16'h0000);
            @(negedge clk);
        end

        // R7: mid-period writes held until wrap (model times the switch)
        tag = "R7";
        wr_exp(6);
        wait_cyc(300);
        wait_cyc(37);
        wr_duty(3, 17); wr_sel(1, 12); wr_exp(5);
        wait_cyc(400);

        // R8: registered output latency across a reset pulse
        tag = "R8";
        rst_n = 1'b0;
        wait_cyc(2);
        chk("R8 reset output", pwm_out, 16'h0000);
        rst_n = 1'b1;
        wr_duty(0, 255); wr_exp(0);
        wait_cyc(50);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule